// File: doc/BRIEF.md
# Host Slave Interface Freeze Gate

This block sits between an external host bus and the FIFO datapath of an I/O processor. Each host strobe is turned into one decoded operation. The strobe is qualified by an active-low chip select, an active-low DMA acknowledge and a 3-bit register address. Each operation is issued as a one-cycle code to the datapath, and host read data is returned on a registered bus.

The internal CPU owns a freeze control. While it is in force, the host can only read the status and host control registers. Every other host cycle is dropped without side effects, and the internal DMA is held off. During freeze the CPU may rewrite the FIFO pointer and threshold registers. Outside freeze, the CPU's writes to those registers are discarded. Entering freeze raises an interrupt to the host, and that interrupt stays up until the host reads its status register.

All state is reset by a synchronous active-high reset. Registered outputs change one clock after the edge that samples the stimulus.

Top module: `hsi_freeze_gate`

## Requirements
- R1: After reset the block is frozen and `host_irq` is 1. `host_op`, `host_dout` and `host_ctrl` are 0. `fifo_cfg` holds, from bit 0 upward one byte per register index: index0 boundary 0x40, index1 output read pointer 0x40, index2 output write pointer 0x40, index3 input read pointer 0x00, index4 input write pointer 0x00, index5 input threshold 0x80, index6 output threshold 0x01.
- R2: `freeze` is the inverse of bit 3 of the slave control register, which the CPU writes through `cpu_sc_we`/`cpu_sc_wdata` and which resets to 0x00. A write takes effect on the clock edge that samples it. `dma_en` is always the inverse of `freeze`.
- R3: `host_irq` rises one cycle after `freeze` goes from 0 to 1. It falls only on an accepted host status read. A status read that coincides with a freeze entry leaves it at 1.
- R4: A host status read returns a byte with bit 1 equal to `freeze` (sampled at the access edge) and all other bits 0.
- R5: With `host_dack_n`=1 and `host_cs_n`=0, a cycle is recognized on the first clock in which `host_rd_n` (or `host_wr_n`) is low after being high, and the other strobe is high. Only one access is made per strobe. Address 000 is data (read 1, write 2), 001 the stream command (read 3, write 4), 010 status (read 9, writes ignored), 011 host control (read 10, write 11) and 100 the immediate command (read 5, write 6). Any other address, both strobes low, or both selects high, gives no access. `host_op` shows the code for one cycle and is 0 otherwise.
- R6: With `host_dack_n`=0, a read strobe is a DMA read (code 7) and a write strobe is a DMA write (code 8), whatever the address or chip select.
- R7: While frozen, only status reads (9) and host control reads (10) are accepted. Every other access leaves `host_op` at 0 and `host_ctrl` and `host_irq` unchanged. A suppressed read returns 0x00.
- R8: An accepted host control write stores `host_din` in `host_ctrl`, and a host control read returns it.
- R9: A CPU write to `fifo_cfg` register index `cpu_cfg_sel` takes effect only while frozen and only for indices 0 to 6. Any other write leaves `fifo_cfg` unchanged.
- R10: Accepted data, command and DMA reads return `fifo_rdata`. `host_dout` holds its value in cycles with no recognized read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_dack_n | input | 1 | Host DMA acknowledge, active low |
| host_addr | input | 3 | Host register address |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Registered host read data |
| host_irq | output | 1 | Interrupt request to host |
| host_op | output | 4 | Accepted operation code, one-cycle |
| fifo_rdata | input | 8 | Read data from FIFO datapath |
| cpu_sc_we | input | 1 | CPU slave control write enable |
| cpu_sc_wdata | input | 8 | CPU slave control write data |
| cpu_cfg_we | input | 1 | CPU FIFO control write enable |
| cpu_cfg_sel | input | 3 | FIFO control register index |
| cpu_cfg_wdata | input | 8 | FIFO control write data |
| slave_ctrl | output | 8 | Slave control register contents |
| freeze | output | 1 | Freeze in force |
| dma_en | output | 1 | Internal DMA permitted |
| host_ctrl | output | 8 | Host control register |
| fifo_cfg | output | 56 | FIFO pointer and threshold registers, one byte per index |

## Verification
The in-line assertions check the interrupt on every cycle: it sets after a freeze entry, it holds until a status read, it clears on a status read, and it never rises without an entry. They also check that no gated operation appears after a frozen cycle, and that the host control and FIFO configuration registers stay stable whenever writes are not allowed. A status read is checked against the freeze state of the previous cycle. The bench's scenarios are needed for the rest:
- one access per strobe held for several cycles;
- addresses being ignored under DMA acknowledge;
- the exact reset bytes;
- writes to the out-of-range index;
- the coincidence of a status read with a freeze entry.

// File: rtl/hsi_pkg.sv
package hsi_pkg;

  typedef enum logic [3:0] {
    OP_NONE    = 4'd0,
    OP_DAT_RD  = 4'd1,
    OP_DAT_WR  = 4'd2,
    OP_STR_RD  = 4'd3,
    OP_STR_WR  = 4'd4,
    OP_IMM_RD  = 4'd5,
    OP_IMM_WR  = 4'd6,
    OP_DMA_RD  = 4'd7,
    OP_DMA_WR  = 4'd8,
    OP_STAT_RD = 4'd9,
    OP_HCTL_RD = 4'd10,
    OP_HCTL_WR = 4'd11
  } host_op_e;

  // address map seen by the host when DMA acknowledge is inactive
  localparam logic [2:0] ADR_DATA = 3'b000;
  localparam logic [2:0] ADR_STRM = 3'b001;
  localparam logic [2:0] ADR_STAT = 3'b010;
  localparam logic [2:0] ADR_HCTL = 3'b011;
  localparam logic [2:0] ADR_IMM  = 3'b100;

  localparam int FRZ_BIT      = 3;  // slave control bit: 0 = frozen
  localparam int STAT_FRZ_BIT = 1;  // status bit reporting freeze

  function automatic logic op_is_read(host_op_e op);
    return op inside {OP_DAT_RD, OP_STR_RD, OP_IMM_RD, OP_DMA_RD,
                      OP_STAT_RD, OP_HCTL_RD};
  endfunction

  function automatic logic op_frz_ok(host_op_e op);
    return op inside {OP_NONE, OP_STAT_RD, OP_HCTL_RD};
  endfunction

endpackage

// File: rtl/hsi_decode.sv
module hsi_decode
  import hsi_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          dack_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          freeze,
  output host_op_e      op_raw,
  output host_op_e      op_acc
);

  logic rd_q, wr_q;
  logic rd_fall, wr_fall;

  // strobe history follows the pins even in reset, so a strobe held
  // low through reset never yields an access afterwards
  always_ff @(posedge clk) begin
    rd_q <= rd_n;
    wr_q <= wr_n;
  end

  assign rd_fall = !rd_n && rd_q && wr_n;
  assign wr_fall = !wr_n && wr_q && rd_n;

  always_comb begin
    op_raw = OP_NONE;
    if (!dack_n) begin
      if (rd_fall)      op_raw = OP_DMA_RD;
      else if (wr_fall) op_raw = OP_DMA_WR;
    end else if (!cs_n && (rd_fall || wr_fall)) begin
      unique case (addr)
        AW'(ADR_DATA): op_raw = rd_fall ? OP_DAT_RD  : OP_DAT_WR;
        AW'(ADR_STRM): op_raw = rd_fall ? OP_STR_RD  : OP_STR_WR;
        AW'(ADR_STAT): op_raw = rd_fall ? OP_STAT_RD : OP_NONE;
        AW'(ADR_HCTL): op_raw = rd_fall ? OP_HCTL_RD : OP_HCTL_WR;
        AW'(ADR_IMM):  op_raw = rd_fall ? OP_IMM_RD  : OP_IMM_WR;
        default:       op_raw = OP_NONE;
      endcase
    end
  end

  assign op_acc = (freeze && !op_frz_ok(op_raw)) ? OP_NONE : op_raw;

  // R5
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && $past(!rd_n)) |-> !op_is_read(op_raw));

  // R5
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && $past(!wr_n)) |-> (op_raw == OP_NONE || op_is_read(op_raw)));

endmodule

// File: rtl/hsi_irq_ctl.sv
module hsi_irq_ctl
  import hsi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sc_we,
  input  logic [DW-1:0] sc_wdata,
  input  logic          stat_rd,
  output logic [DW-1:0] sc_o,
  output logic          freeze_o,
  output logic          irq_o
);

  logic [DW-1:0] sc_q;
  logic          frz_q;
  logic          irq_q;
  logic          entry;

  always_ff @(posedge clk) begin
    if (rst)        sc_q <= '0;
    else if (sc_we) sc_q <= sc_wdata;
  end

  assign freeze_o = !sc_q[FRZ_BIT];
  assign entry    = freeze_o && !frz_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frz_q <= 1'b1;
      irq_q <= 1'b1;
    end else begin
      frz_q <= freeze_o;
      if (entry)        irq_q <= 1'b1;
      else if (stat_rd) irq_q <= 1'b0;
    end
  end

  assign sc_o  = sc_q;
  assign irq_o = irq_q;

  // R3
  freeze_entry_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(freeze_o) |=> irq_o);

  // R3
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !$rose(freeze_o)) |=> !irq_o);

  // R3
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !stat_rd) |=> irq_o);

  // R3
  irq_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_o && !$rose(freeze_o)) |=> !irq_o);

endmodule

// File: rtl/hsi_cfg_bank.sv
module hsi_cfg_bank #(
  parameter int DW   = 8,
  parameter int NREG = 7,
  localparam int SELW = (NREG > 1) ? $clog2(NREG + 1) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze,
  input  logic             we,
  input  logic [SELW-1:0]  sel,
  input  logic [DW-1:0]    wdata,
  output logic [NREG*DW-1:0] cfg_o
);

  function automatic logic [DW-1:0] rst_val(int idx);
    case (idx)
      0, 1, 2: return DW'(64);
      5:       return DW'(128);
      6:       return DW'(1);
      default: return '0;
    endcase
  endfunction

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] r_q;
    logic          hit;
    assign hit = we && freeze && (sel == SELW'(g));
    always_ff @(posedge clk) begin
      if (rst)      r_q <= rst_val(g);
      else if (hit) r_q <= wdata;
    end
    assign cfg_o[g*DW +: DW] = r_q;
  end

  // R9
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    !freeze |=> $stable(cfg_o));

  // R9
  cfg_range_chk: assert property (@(posedge clk) disable iff (rst)
    (sel >= SELW'(NREG)) |=> $stable(cfg_o));

endmodule

// File: rtl/hsi_freeze_gate.sv
module hsi_freeze_gate
  import hsi_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 3,
  parameter int NREG = 7,
  localparam int SELW = (NREG > 1) ? $clog2(NREG + 1) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_cs_n,
  input  logic               host_dack_n,
  input  logic [AW-1:0]      host_addr,
  input  logic               host_rd_n,
  input  logic               host_wr_n,
  input  logic [DW-1:0]      host_din,
  output logic [DW-1:0]      host_dout,
  output logic               host_irq,
  output logic [3:0]         host_op,
  input  logic [DW-1:0]      fifo_rdata,
  input  logic               cpu_sc_we,
  input  logic [DW-1:0]      cpu_sc_wdata,
  input  logic               cpu_cfg_we,
  input  logic [SELW-1:0]    cpu_cfg_sel,
  input  logic [DW-1:0]      cpu_cfg_wdata,
  output logic [DW-1:0]      slave_ctrl,
  output logic               freeze,
  output logic               dma_en,
  output logic [DW-1:0]      host_ctrl,
  output logic [NREG*DW-1:0] fifo_cfg
);

  host_op_e      op_raw, op_acc;
  host_op_e      op_q;
  logic [DW-1:0] dout_q, hctl_q, rd_val, status;
  logic          frz;

  hsi_decode #(.AW(AW)) u_decode (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (host_cs_n),
    .dack_n (host_dack_n),
    .addr   (host_addr),
    .rd_n   (host_rd_n),
    .wr_n   (host_wr_n),
    .freeze (frz),
    .op_raw (op_raw),
    .op_acc (op_acc)
  );

  hsi_irq_ctl #(.DW(DW)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .sc_we    (cpu_sc_we),
    .sc_wdata (cpu_sc_wdata),
    .stat_rd  (op_acc == OP_STAT_RD),
    .sc_o     (slave_ctrl),
    .freeze_o (frz),
    .irq_o    (host_irq)
  );

  hsi_cfg_bank #(.DW(DW), .NREG(NREG)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .freeze (frz),
    .we     (cpu_cfg_we),
    .sel    (cpu_cfg_sel),
    .wdata  (cpu_cfg_wdata),
    .cfg_o  (fifo_cfg)
  );

  always_comb begin
    status               = '0;
    status[STAT_FRZ_BIT] = frz;
  end

  always_comb begin
    case (op_acc)
      OP_STAT_RD: rd_val = status;
      OP_HCTL_RD: rd_val = hctl_q;
      OP_NONE:    rd_val = '0;
      default:    rd_val = fifo_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_NONE;
      dout_q <= '0;
      hctl_q <= '0;
    end else begin
      op_q <= op_acc;
      if (op_is_read(op_raw)) dout_q <= rd_val;
      if (op_acc == OP_HCTL_WR) hctl_q <= host_din;
    end
  end

  assign host_op   = op_q;
  assign host_dout = dout_q;
  assign host_ctrl = hctl_q;
  assign freeze    = frz;
  assign dma_en    = !frz;

  // R7
  frozen_gate_chk: assert property (@(posedge clk) disable iff (rst)
    frz |=> op_frz_ok(op_q));

  // R7
  hctl_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    frz |=> $stable(hctl_q));

  // R4
  status_value_chk: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_STAT_RD) |->
      (dout_q == (DW'($past(frz)) << STAT_FRZ_BIT)));

  // R2
  dma_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_sc_we) |=> (dma_en == $past(cpu_sc_wdata[FRZ_BIT])));

endmodule

// File: tb/hsi_freeze_gate_tb_top.sv
module hsi_freeze_gate_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_cs_n = 1'b1, host_dack_n = 1'b1;
  logic [2:0] host_addr = '0;
  logic       host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic [7:0] host_din = '0;
  logic [7:0] host_dout;
  logic       host_irq;
  logic [3:0] host_op;
  logic [7:0] fifo_rdata = 8'hC3;
  logic       cpu_sc_we = 1'b0;
  logic [7:0] cpu_sc_wdata = '0;
  logic       cpu_cfg_we = 1'b0;
  logic [2:0] cpu_cfg_sel = '0;
  logic [7:0] cpu_cfg_wdata = '0;
  logic [7:0] slave_ctrl;
  logic       freeze, dma_en;
  logic [7:0] host_ctrl;
  logic [55:0] fifo_cfg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  hsi_freeze_gate dut_i (
    .clk, .rst, .host_cs_n, .host_dack_n, .host_addr, .host_rd_n,
    .host_wr_n, .host_din, .host_dout, .host_irq, .host_op, .fifo_rdata,
    .cpu_sc_we, .cpu_sc_wdata, .cpu_cfg_we, .cpu_cfg_sel, .cpu_cfg_wdata,
    .slave_ctrl, .freeze, .dma_en, .host_ctrl, .fifo_cfg
  );

  // ---------------- reference model ----------------
  logic [7:0] m_sc, m_hctl, m_dout, m_cfg [7];
  logic [3:0] m_op;
  logic       m_irq, m_prev_frz, m_rdq = 1'b1, m_wdq = 1'b1;

  function automatic logic [3:0] model_decode(bit rdf, bit wrf);
    if (!rdf && !wrf) return 4'd0;
    if (!host_dack_n) return rdf ? 4'd7 : 4'd8;
    if (host_cs_n) return 4'd0;
    case (host_addr)
      3'd0: return rdf ? 4'd1 : 4'd2;
      3'd1: return rdf ? 4'd3 : 4'd4;
      3'd2: return rdf ? 4'd9 : 4'd0;
      3'd3: return rdf ? 4'd10 : 4'd11;
      3'd4: return rdf ? 4'd5 : 4'd6;
      default: return 4'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sc = 8'h00; m_hctl = 8'h00; m_dout = 8'h00; m_op = 4'd0;
      m_irq = 1'b1; m_prev_frz = 1'b1;
      m_cfg[0] = 8'h40; m_cfg[1] = 8'h40; m_cfg[2] = 8'h40;
      m_cfg[3] = 8'h00; m_cfg[4] = 8'h00; m_cfg[5] = 8'h80; m_cfg[6] = 8'h01;
    end else begin
      bit frz, rdf, wrf, is_rd;
      logic [3:0] op, acc;
      frz = !m_sc[3];
      rdf = !host_rd_n && m_rdq && host_wr_n;
      wrf = !host_wr_n && m_wdq && host_rd_n;
      op  = model_decode(rdf, wrf);
      acc = (frz && op != 4'd9 && op != 4'd10) ? 4'd0 : op;
      is_rd = (op != 4'd0) && rdf;
      if (is_rd) begin
        if (acc == 4'd0)       m_dout = 8'h00;
        else if (acc == 4'd9)  m_dout = {6'b0, frz, 1'b0};
        else if (acc == 4'd10) m_dout = m_hctl;
        else                   m_dout = fifo_rdata;
      end
      m_op = acc;
      if (acc == 4'd11) m_hctl = host_din;
      if (frz && !m_prev_frz) m_irq = 1'b1;
      else if (acc == 4'd9)   m_irq = 1'b0;
      m_prev_frz = frz;
      if (cpu_cfg_we && frz && cpu_cfg_sel < 3'd7) m_cfg[cpu_cfg_sel] = cpu_cfg_wdata;
      if (cpu_sc_we) m_sc = cpu_sc_wdata;
    end
    m_rdq = host_rd_n;
    m_wdq = host_wr_n;
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R5 host_op", host_op, m_op);
      chk("R10 host_dout", host_dout, m_dout);
      chk("R3 host_irq", host_irq, m_irq);
      chk("R2 freeze", freeze, !m_sc[3]);
      chk("R2 dma_en", dma_en, m_sc[3]);
      chk("R8 host_ctrl", host_ctrl, m_hctl);
      chk("R9 fifo_cfg", fifo_cfg,
          {m_cfg[6], m_cfg[5], m_cfg[4], m_cfg[3], m_cfg[2], m_cfg[1], m_cfg[0]});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic host_cyc(bit is_rd, bit cs, bit dk, logic [2:0] a,
                          logic [7:0] d, output logic [3:0] op_o);
    host_cs_n = cs; host_dack_n = dk; host_addr = a; host_din = d;
    if (is_rd) host_rd_n = 1'b0; else host_wr_n = 1'b0;
    @(negedge clk);
    op_o = host_op;
    host_rd_n = 1'b1; host_wr_n = 1'b1; host_cs_n = 1'b1; host_dack_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic sc_write(logic [7:0] v);
    cpu_sc_we = 1'b1; cpu_sc_wdata = v;
    @(negedge clk);
    cpu_sc_we = 1'b0;
  endtask

  task automatic cfg_write(logic [2:0] s, logic [7:0] v);
    cpu_cfg_we = 1'b1; cpu_cfg_sel = s; cpu_cfg_wdata = v;
    @(negedge clk);
    cpu_cfg_we = 1'b0;
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    logic [3:0] op;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 freeze", freeze, 1);
    chk("R1 irq", host_irq, 1);
    chk("R1 op", host_op, 0);
    chk("R1 dout", host_dout, 0);
    chk("R1 hctl", host_ctrl, 0);
    chk("R1 cfg", fifo_cfg, 56'h01_80_00_00_40_40_40);

    // R7 frozen: blocked accesses
    host_cyc(1, 0, 1, 3'd0, 8'h00, op);
    chk("R7 data read op", op, 0);
    chk("R7 data read dout", host_dout, 8'h00);
    chk("R7 irq untouched", host_irq, 1);
    host_cyc(0, 0, 1, 3'd3, 8'h5A, op);
    chk("R7 hctl write op", op, 0);
    chk("R7 hctl write ignored", host_ctrl, 8'h00);
    host_cyc(1, 1, 0, 3'd5, 8'h00, op);
    chk("R7 dma read op", op, 0);
    host_cyc(0, 0, 1, 3'd1, 8'h11, op);
    chk("R7 stream write op", op, 0);

    // R4 / R3 status read while frozen
    host_cyc(1, 0, 1, 3'd2, 8'h00, op);
    chk("R4 status op", op, 9);
    chk("R4 status value frozen", host_dout, 8'h02);
    chk("R3 irq cleared", host_irq, 0);
    host_cyc(1, 0, 1, 3'd3, 8'h00, op);
    chk("R7 hctl read op", op, 10);
    chk("R7 hctl read value", host_dout, 8'h00);

    // R9 cfg writes while frozen
    cfg_write(3'd6, 8'h05);
    cfg_write(3'd0, 8'h30);
    cfg_write(3'd7, 8'hFF);
    @(negedge clk);
    chk("R9 frozen writes", fifo_cfg, 56'h05_80_00_00_40_40_30);

    // R2 unfreeze
    sc_write(8'h08);
    chk("R2 unfrozen", freeze, 0);
    chk("R2 dma_en", dma_en, 1);
    chk("R3 no irq on exit", host_irq, 0);
    cfg_write(3'd1, 8'h77);
    @(negedge clk);
    chk("R9 write discarded", fifo_cfg, 56'h05_80_00_00_40_40_30);

    // R5 / R10 normal operation
    host_cyc(1, 0, 1, 3'd0, 8'h00, op);
    chk("R5 data read op", op, 1);
    chk("R10 data read value", host_dout, 8'hC3);
    host_cyc(0, 0, 1, 3'd0, 8'h12, op);   chk("R5 data write op", op, 2);
    chk("R10 dout held on write", host_dout, 8'hC3);
    fifo_rdata = 8'h3C;
    host_cyc(1, 0, 1, 3'd1, 8'h00, op);   chk("R5 stream read op", op, 3);
    chk("R10 stream read value", host_dout, 8'h3C);
    host_cyc(0, 0, 1, 3'd1, 8'h00, op);   chk("R5 stream write op", op, 4);
    host_cyc(1, 0, 1, 3'd4, 8'h00, op);   chk("R5 imm read op", op, 5);
    host_cyc(0, 0, 1, 3'd4, 8'h00, op);   chk("R5 imm write op", op, 6);
    host_cyc(0, 0, 1, 3'd2, 8'h00, op);   chk("R5 status write none", op, 0);
    host_cyc(1, 0, 1, 3'd2, 8'h00, op);
    chk("R4 status value normal", host_dout, 8'h00);
    host_cyc(0, 0, 1, 3'd3, 8'hA5, op);   chk("R8 hctl write op", op, 11);
    chk("R8 hctl stored", host_ctrl, 8'hA5);
    host_cyc(1, 0, 1, 3'd3, 8'h00, op);   chk("R8 hctl readback", host_dout, 8'hA5);
    host_cyc(1, 0, 1, 3'd6, 8'h00, op);   chk("R5 bad address", op, 0);
    chk("R10 dout held", host_dout, 8'hA5);
    host_cyc(1, 1, 1, 3'd0, 8'h00, op);   chk("R5 unselected", op, 0);

    // R6 DMA ignores address and chip select
    fifo_rdata = 8'h99;
    host_cyc(1, 1, 0, 3'd7, 8'h00, op);   chk("R6 dma read op", op, 7);
    chk("R6 dma read value", host_dout, 8'h99);
    host_cyc(0, 0, 0, 3'd3, 8'h44, op);   chk("R6 dma write op", op, 8);
    chk("R6 dma write not hctl", host_ctrl, 8'hA5);

    // R5 held strobe: one access only
    host_cs_n = 0; host_addr = 3'd0; host_rd_n = 0;
    @(negedge clk); chk("R5 held first", host_op, 1);
    @(negedge clk); chk("R5 held second", host_op, 0);
    @(negedge clk); chk("R5 held third", host_op, 0);
    host_rd_n = 1; host_cs_n = 1;
    @(negedge clk);
    // both strobes low
    host_cs_n = 0; host_addr = 3'd3; host_din = 8'h01; host_rd_n = 0; host_wr_n = 0;
    @(negedge clk); chk("R5 both strobes", host_op, 0);
    host_rd_n = 1; host_wr_n = 1; host_cs_n = 1;
    @(negedge clk);
    chk("R5 both strobes hctl", host_ctrl, 8'hA5);

    // R3 re-freeze raises irq one cycle later
    sc_write(8'h00);
    chk("R2 refrozen", freeze, 1);
    chk("R3 irq not yet", host_irq, 0);
    @(negedge clk);
    chk("R3 irq on entry", host_irq, 1);
    host_cyc(1, 0, 1, 3'd2, 8'h00, op);
    chk("R3 irq cleared again", host_irq, 0);

    // R3 status read coinciding with entry
    sc_write(8'h08);
    @(negedge clk);
    sc_write(8'h00);
    host_cyc(1, 0, 1, 3'd2, 8'h00, op);
    chk("R3 coincident read op", op, 9);
    chk("R3 coincident irq kept", host_irq, 1);
    host_cyc(1, 0, 1, 3'd2, 8'h00, op);
    chk("R3 later read clears", host_irq, 0);

    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule